// File: doc/BRIEF.md
# Machine Status Word Control Unit

This unit keeps the low control bits of a processor's main control register and carries out the three system operations that act on them. A one-cycle strobe presents an opcode and a 16-bit source operand. The unit can clear the task-switched flag. It can load the lowest four control bits from the operand. It can also return the low half of the register as a 16-bit result.

Protection enable is sticky. A load can switch protected mode on, but no load can switch it off; only reset clears it. The register is 32 bits wide. Bits above the four writable ones are plain storage: they reset to zero and no operation changes them. The 16-bit store result is registered, and a valid flag marks it for exactly one cycle.

Top module: `msw_ctrl_unit`

## Requirements
- R1: After reset, `ctrl_o` is zero, `prot_active_o` is low and `store_valid_o` is low.
- R2: A strobe with opcode 2'b01 (clear task-switched) clears bit 3 of `ctrl_o` at the clock edge. Every other bit keeps its value.
- R3: A strobe with opcode 2'b10 (load) copies `src_i[3:1]` into `ctrl_o[3:1]` (bit 1 monitor-coprocessor, bit 2 emulate, bit 3 task-switched). Bits 31:4 are unchanged.
- R4: A load whose `src_i[0]` is 1 sets `ctrl_o[0]` (protection enable), and protected mode becomes active.
- R5: A load whose `src_i[0]` is 0 leaves `ctrl_o[0]` as it was, so an active protected mode stays active.
- R6: A load ignores `src_i[15:4]`: two loads whose operands differ only in those bits give the same `ctrl_o`.
- R7: A strobe with opcode 2'b11 (store) puts the `ctrl_o[15:0]` value seen in the strobe cycle on `store_data_o` after the edge. `store_valid_o` is high for that one following cycle only, and `ctrl_o` is unchanged.
- R8: A cycle without a strobe, or a strobe with opcode 2'b00, changes nothing in `ctrl_o`. `store_valid_o` is low in the cycle after it.
- R9: `prot_active_o` always equals `ctrl_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 2 | 00 none, 01 clear task-switched, 10 load, 11 store |
| src_i | input | 16 | Source operand for load |
| ctrl_o | output | 32 | Current control register |
| store_data_o | output | 16 | Registered store result |
| store_valid_o | output | 1 | Store result valid, one cycle |
| prot_active_o | output | 1 | Protected mode active |

## Verification
The bound properties check every cycle that:
- clearing the task-switched flag touches only bit 3;
- a load changes only bits 3:1 and can only raise bit 0;
- protection enable never falls outside reset;
- a store returns the prior low half with a single-cycle valid;
- idle cycles leave the register still.

Only the bench's scenarios can show the reset values themselves. The same holds for the insensitivity to operand bits 15:4, which the bench shows by comparing loads that differ only in those bits. Sticky protection across a load of zero after a set is also shown by a directed scenario, as is the match between random operation streams and an independent model.

// File: rtl/msw_ctrl_unit.sv
module msw_ctrl_unit #(
  parameter int CR_W    = 32,
  parameter int SRC_W   = 16,
  parameter int STORE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_code_i,
  input  logic [SRC_W-1:0]   src_i,
  output logic [CR_W-1:0]    ctrl_o,
  output logic [STORE_W-1:0] store_data_o,
  output logic               store_valid_o,
  output logic               prot_active_o
);
  localparam logic [1:0] OpClts  = 2'b01;
  localparam logic [1:0] OpLoad  = 2'b10;
  localparam logic [1:0] OpStore = 2'b11;
  localparam int PeBit = 0;
  localparam int TsBit = 3;

  logic [CR_W-1:0]    cr_q;
  logic [STORE_W-1:0] st_q;
  logic               vld_q;

  wire do_clts  = op_valid_i && op_code_i == OpClts;
  wire do_load  = op_valid_i && op_code_i == OpLoad;
  wire do_store = op_valid_i && op_code_i == OpStore;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cr_q  <= '0;
      st_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= do_store;
      if (do_store) st_q <= cr_q[STORE_W-1:0];
      if (do_clts) cr_q[TsBit] <= 1'b0;
      if (do_load) begin
        cr_q[TsBit:PeBit+1] <= src_i[TsBit:PeBit+1];
        cr_q[PeBit]         <= cr_q[PeBit] | src_i[PeBit];
      end
    end
  end

  assign ctrl_o        = cr_q;
  assign store_data_o  = st_q;
  assign store_valid_o = vld_q;
  assign prot_active_o = cr_q[PeBit];
endmodule

// File: rtl/msw_ctrl_unit_chk.sv
module msw_ctrl_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        op_valid_i,
  input logic [1:0]  op_code_i,
  input logic [15:0] src_i,
  input logic [31:0] ctrl_o,
  input logic [15:0] store_data_o,
  input logic        store_valid_o,
  input logic        prot_active_o
);
  p_clts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'b01) |=>
      (ctrl_o[3] == 1'b0 && ctrl_o[2:0] == $past(ctrl_o[2:0]) && ctrl_o[31:4] == $past(ctrl_o[31:4])));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'b10) |=>
      (ctrl_o[3:1] == $past(src_i[3:1]) && ctrl_o[31:4] == $past(ctrl_o[31:4])));

  p_pe_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'b10 && src_i[0]) |=> prot_active_o);

  p_pe_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[0] |=> ctrl_o[0]);

  p_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == 2'b11) |=>
      (store_valid_o && store_data_o == $past(ctrl_o[15:0]) && $stable(ctrl_o)));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i || op_code_i == 2'b00) |=> ($stable(ctrl_o) && !store_valid_o));

  p_prot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_active_o == ctrl_o[0]);
endmodule

bind msw_ctrl_unit msw_ctrl_unit_chk chk_i (.*);

// File: tb/msw_ctrl_unit_tb.sv
module msw_ctrl_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_code_i = 2'b00;
  logic [15:0] src_i = '0;
  logic [31:0] ctrl_o;
  logic [15:0] store_data_o;
  logic        store_valid_o;
  logic        prot_active_o;

  int vectors = 0;
  int fails = 0;
  logic [31:0] m_cr;
  logic [15:0] m_st;
  logic        m_vld;

  always #2 clk_i = ~clk_i;

  msw_ctrl_unit dut_i (.*);

  function automatic logic [31:0] next_cr(logic [31:0] cr, logic v, logic [1:0] op, logic [15:0] s);
    logic [31:0] n = cr;
    if (v && op == 2'b01) n[3] = 1'b0;
    if (v && op == 2'b10) begin
      n[3:1] = s[3:1];
      n[0] = cr[0] | s[0];
    end
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic v, logic [1:0] op, logic [15:0] s);
    op_valid_i = v; op_code_i = op; src_i = s;
    @(posedge clk_i);
    m_vld = v && op == 2'b11;
    if (m_vld) m_st = m_cr[15:0];
    m_cr = next_cr(m_cr, v, op, s);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    check("R2/R3/R8 ctrl", ctrl_o, m_cr);
    check("R9 prot", {31'b0, prot_active_o}, {31'b0, m_cr[0]});
    check("R7/R8 valid", {31'b0, store_valid_o}, {31'b0, m_vld});
    if (m_vld) check("R7 data", {16'b0, store_data_o}, {16'b0, m_st});
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; op_valid_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    m_cr = '0; m_st = '0; m_vld = 1'b0;
    check("R1 ctrl", ctrl_o, 32'h0);
    check("R1 prot", {31'b0, prot_active_o}, 32'h0);
    check("R1 valid", {31'b0, store_valid_o}, 32'h0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5eed_0042));
    @(negedge clk_i);
    do_reset();
    // R6: upper operand bits have no effect
    apply(1'b1, 2'b10, 16'hFFF0);
    check("R6 upper ignored", ctrl_o, 32'h0);
    apply(1'b1, 2'b10, 16'h000A);
    keep = ctrl_o;
    apply(1'b1, 2'b10, 16'h5A0A);
    check("R6 same result", ctrl_o, keep);
    // R4 then R5: set PE, load zero, PE stays
    apply(1'b1, 2'b10, 16'h000F);
    check("R4 pe set", {31'b0, prot_active_o}, 32'h1);
    apply(1'b1, 2'b10, 16'h0000);
    check("R5 pe sticky", ctrl_o, 32'h1);
    // R2: clear TS only
    apply(1'b1, 2'b10, 16'h000E);
    apply(1'b1, 2'b01, 16'hFFFF);
    check("R2 clts", ctrl_o, 32'h7);
    // R7: store then idle drops valid
    apply(1'b1, 2'b11, 16'h0000);
    check("R7 store value", {16'b0, store_data_o}, 32'h7);
    apply(1'b0, 2'b11, 16'h0000);
    check("R7 one cycle", {31'b0, store_valid_o}, 32'h0);
    apply(1'b1, 2'b00, 16'h000F);
    check("R8 nop", ctrl_o, 32'h7);
    do_reset();
    for (int i = 0; i < 400; i++)
      apply(($urandom % 4) != 0, 2'($urandom), 16'($urandom));
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule